// File: doc/BRIEF.md
# Command Register with Clock-Domain Handshake

This block is a small command and status register for a serial-link controller. It sits in the application clock domain, where software writes it and reads it back. Its control bits are carried into a separate core clock domain. The bits are: link-training enable, outbound address-translation enable, and a mode bit that swaps in an alternate register view. A link-state code from the core domain is carried back and shows up as a single link-up flag in the read value.

The mode bit crosses with a full handshake. The requested value goes through a synchroniser into the core domain. The core-side copy then comes back through a second synchroniser. The read value of the mode bit is that returned acknowledgement, not the written value. Software therefore writes the bit and polls it until it reads the new value, and at that point the core domain has already taken the change. The same applies when the bit is set and when it is cleared. A rising edge of the training enable, as seen in the core domain, produces a one-cycle start pulse for the link state machine. That state machine lies outside this block.

Top module: `cmdreg_xdom`

## Requirements
- R1: After reset, the read value is all zeros and every core-side output (training enable, translation enable, alternate view, start pulse) is 0.
- R2: Bit 0 of a write is the link-training enable. It reads back at bit 0 in the first application cycle after the write, and it appears on the core-side training-enable output after the crossing.
- R3: Bit 1 of a write is the outbound-translation enable. It reads back at bit 1 in the first application cycle after the write, and it appears on the core-side translation-enable output after the crossing.
- R4: Bit 5 of a write requests the alternate register view. Read bit 5 keeps its old value in the first application cycle after a write that sets it. It turns to 1 only after the request has crossed to the core side and the acknowledgement has come back, and by then the core-side alternate-view output is already 1.
- R5: A write that clears bit 5 behaves the same way. Read bit 5 stays 1 in the first cycle after the write, then falls to 0 once the core side has dropped its alternate-view output.
- R6: Every read bit other than 0, 1, 5 and 8 reads as 0, even after a write of all ones.
- R7: Read bit 8 is 1 exactly when the 5-bit core link-state input, once synchronised into the application domain, equals 0x11 (the fully active link state). Any other code, including 0x10 and 0x01, reads as 0.
- R8: The core-side start output pulses high for exactly one core cycle on each 0-to-1 change of the core-side training enable. Rewriting an enable that is already 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| appClk | input | 1 | Application (register) clock |
| appRstN | input | 1 | Asynchronous active-low reset, application domain |
| wrEn | input | 1 | Register write strobe, one application cycle |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Current read value of the register |
| coreClk | input | 1 | Core clock |
| coreRstN | input | 1 | Asynchronous active-low reset, core domain |
| coreLinkState | input | LINK_W | Link-state code from the core domain |
| coreTrainEn | output | 1 | Training enable in the core domain |
| coreXlatEn | output | 1 | Translation enable in the core domain |
| coreAltView | output | 1 | Alternate-view select in the core domain |
| coreTrainStart | output | 1 | One-cycle pulse when training is enabled |

## Verification
The mode bit is exercised with a set followed by a clear. In each case the bench samples the cycle right after the write, which separates a design that echoes the written value from one that returns the acknowledgement. It then polls until the bit changes and checks the core-side output at that moment, which shows whether the change really crossed before it became visible. The training enable is driven through 0-to-1, 1-to-1 and 1-to-0-to-1 sequences, which separates edge detection from level detection on the start pulse. The link-state input is driven to 0x11 and to codes that differ from it in a single bit, which shows whether the compare covers every bit. An all-ones write exposes any unused bit that leaks into the read value.

// File: rtl/cmdreg_pkg.sv
`timescale 1ns/1ps
package cmdreg_pkg;
  // Field positions decoded by software and by the core domain.
  localparam int TRAIN_BIT  = 0;
  localparam int XLAT_BIT   = 1;
  localparam int ALT_BIT    = 5;
  localparam int LINKUP_BIT = 8;

  // Strobes passed from write decode to the datapath.
  typedef struct packed {
    logic load;
    logic train;
    logic xlat;
    logic alt;
  } cmdStrobe_t;
endpackage

// File: rtl/cmdreg_sync.sv
`timescale 1ns/1ps
module cmdreg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
      end
      // R4: the output repeats the input exactly two sampling edges later
      p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
        (age == 2'd2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/cmdreg_ctrl.sv
`timescale 1ns/1ps
module cmdreg_ctrl
  import cmdreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output cmdStrobe_t        strobe
);
  always_comb begin
    strobe       = '0;
    strobe.load  = wrEn;
    strobe.train = wrData[TRAIN_BIT];
    strobe.xlat  = wrData[XLAT_BIT];
    strobe.alt   = wrData[ALT_BIT];
  end
endmodule

// File: rtl/cmdreg_dpath.sv
`timescale 1ns/1ps
module cmdreg_dpath
  import cmdreg_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              LINK_W      = 5,
  parameter logic [LINK_W-1:0] LINK_L0   = 5'h11,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              appClk,
  input  logic              appRstN,
  input  cmdStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic [LINK_W-1:0] coreLinkState,
  output logic              coreTrainEn,
  output logic              coreXlatEn,
  output logic              coreAltView,
  output logic              coreTrainStart
);
  localparam int CTL_W = 3;

  // Application-domain request register
  logic trainReq, xlatReq, altReq;
  always_ff @(posedge appClk or negedge appRstN) begin
    if (!appRstN) begin
      trainReq <= 1'b0;
      xlatReq  <= 1'b0;
      altReq   <= 1'b0;
    end else if (strobe.load) begin
      trainReq <= strobe.train;
      xlatReq  <= strobe.xlat;
      altReq   <= strobe.alt;
    end
  end

  // Forward crossing into the core domain
  logic [CTL_W-1:0] coreCtl;
  cmdreg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_fwdSync (
    .clk (coreClk), .rstN(coreRstN),
    .din ({altReq, xlatReq, trainReq}),
    .dout(coreCtl)
  );
  assign coreTrainEn = coreCtl[0];
  assign coreXlatEn  = coreCtl[1];
  assign coreAltView = coreCtl[2];

  // Training start pulse on a core-side rising enable
  logic trainPrev, startQ;
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      trainPrev <= 1'b0;
      startQ    <= 1'b0;
    end else begin
      trainPrev <= coreCtl[0];
      startQ    <= coreCtl[0] & ~trainPrev;
    end
  end
  assign coreTrainStart = startQ;

  // R8: a start pulse never lasts longer than one core cycle
  p_start_single_r8: assert property (@(posedge coreClk) disable iff (!coreRstN)
    coreTrainStart |=> !coreTrainStart);

  // Return crossing of the alternate-view acknowledgement
  logic ackApp;
  cmdreg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ackSync (
    .clk (appClk), .rstN(appRstN),
    .din (coreCtl[2]),
    .dout(ackApp)
  );

  // Link-state crossing and compare
  logic [LINK_W-1:0] linkApp;
  cmdreg_sync #(.W(LINK_W), .STAGES(SYNC_STAGES)) u_linkSync (
    .clk (appClk), .rstN(appRstN),
    .din (coreLinkState),
    .dout(linkApp)
  );
  logic linkUp;
  assign linkUp = (linkApp == LINK_L0);

  // Read assembly
  always_comb begin
    rdData             = '0;
    rdData[TRAIN_BIT]  = trainReq;
    rdData[XLAT_BIT]   = xlatReq;
    rdData[ALT_BIT]    = ackApp;
    rdData[LINKUP_BIT] = linkUp;
  end

  // R2: a written training enable is visible in the next read
  p_train_read_r2: assert property (@(posedge appClk) disable iff (!appRstN)
    strobe.load |=> (rdData[TRAIN_BIT] == $past(strobe.train)));
  // R3: a written translation enable is visible in the next read
  p_xlat_read_r3: assert property (@(posedge appClk) disable iff (!appRstN)
    strobe.load |=> (rdData[XLAT_BIT] == $past(strobe.xlat)));
endmodule

// File: rtl/cmdreg_xdom.sv
`timescale 1ns/1ps
module cmdreg_xdom
  import cmdreg_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                LINK_W      = 5,
  parameter logic [LINK_W-1:0] LINK_L0     = 5'h11,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              appClk,
  input  logic              appRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic [LINK_W-1:0] coreLinkState,
  output logic              coreTrainEn,
  output logic              coreXlatEn,
  output logic              coreAltView,
  output logic              coreTrainStart
);
  cmdStrobe_t strobe;

  cmdreg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn  (wrEn),
    .wrData(wrData),
    .strobe(strobe)
  );

  cmdreg_dpath #(
    .DATA_W(DATA_W), .LINK_W(LINK_W), .LINK_L0(LINK_L0), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .appClk        (appClk),
    .appRstN       (appRstN),
    .strobe        (strobe),
    .rdData        (rdData),
    .coreClk       (coreClk),
    .coreRstN      (coreRstN),
    .coreLinkState (coreLinkState),
    .coreTrainEn   (coreTrainEn),
    .coreXlatEn    (coreXlatEn),
    .coreAltView   (coreAltView),
    .coreTrainStart(coreTrainStart)
  );
endmodule

// File: tb/sim_cmdreg_xdom.sv
`timescale 1ns/1ps
module sim_cmdreg_xdom;
  localparam int DATA_W = 32;
  localparam int LINK_W = 5;

  logic              appClk = 1'b0, coreClk = 1'b0;
  logic              appRstN = 1'b0, coreRstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [LINK_W-1:0] coreLinkState = '0;
  logic              coreTrainEn, coreXlatEn, coreAltView, coreTrainStart;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 appClk  = ~appClk;   // 200 MHz
  always #3.5 coreClk = ~coreClk;  // unrelated core clock

  cmdreg_xdom u0 (
    .appClk(appClk), .appRstN(appRstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .coreClk(coreClk), .coreRstN(coreRstN), .coreLinkState(coreLinkState),
    .coreTrainEn(coreTrainEn), .coreXlatEn(coreXlatEn), .coreAltView(coreAltView),
    .coreTrainStart(coreTrainStart)
  );

  always @(posedge coreClk) if (coreTrainStart === 1'b1) pulses++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [DATA_W-1:0] v);
    @(negedge appClk); wrEn = 1'b1; wrData = v;
    @(negedge appClk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic settle();
    repeat (12) @(negedge appClk);
    @(negedge coreClk);
  endtask

  task automatic tReset();
    @(negedge appClk);
    check(rdData == '0, "R1 read value", rdData, 0);
    @(negedge coreClk);
    check({coreTrainEn, coreXlatEn, coreAltView, coreTrainStart} == 4'b0,
          "R1 core outputs", {coreTrainEn, coreXlatEn, coreAltView, coreTrainStart}, 0);
  endtask

  task automatic tTrain();
    writeReg(32'h1);
    check(rdData[0] == 1'b1, "R2 train readback", rdData[0], 1);
    settle();
    check(coreTrainEn == 1'b1, "R2 core train enable", coreTrainEn, 1);
    check(pulses == 1, "R8 one pulse on enable", pulses, 1);
    writeReg(32'h1);
    settle();
    check(pulses == 1, "R8 no pulse on rewrite", pulses, 1);
    writeReg(32'h0);
    check(rdData[0] == 1'b0, "R2 train cleared", rdData[0], 0);
    settle();
    check(coreTrainEn == 1'b0, "R2 core train off", coreTrainEn, 0);
    writeReg(32'h1);
    settle();
    check(pulses == 2, "R8 pulse on re-enable", pulses, 2);
  endtask

  task automatic tXlat();
    writeReg(32'h3);
    check(rdData[1:0] == 2'b11, "R3 xlat readback", rdData[1:0], 3);
    settle();
    check(coreXlatEn == 1'b1, "R3 core xlat enable", coreXlatEn, 1);
  endtask

  task automatic tAltSet();
    int n;
    writeReg(32'h23);
    check(rdData[5] == 1'b0, "R4 read lags write", rdData[5], 0);
    n = 1;
    while (rdData[5] !== 1'b1 && n < 30) begin @(negedge appClk); n++; end
    check(rdData[5] == 1'b1, "R4 ack returns", rdData[5], 1);
    check(n >= 2, "R4 crossing latency", n, 2);
    check(coreAltView == 1'b1, "R4 core took view", coreAltView, 1);
  endtask

  task automatic tAltClr();
    int n;
    writeReg(32'h03);
    check(rdData[5] == 1'b1, "R5 read lags clear", rdData[5], 1);
    n = 1;
    while (rdData[5] !== 1'b0 && n < 30) begin @(negedge appClk); n++; end
    check(rdData[5] == 1'b0, "R5 ack cleared", rdData[5], 0);
    check(coreAltView == 1'b0, "R5 core left view", coreAltView, 0);
  endtask

  task automatic tUnused();
    writeReg('1);
    check((rdData & ~32'h123) == '0, "R6 unused bits zero", rdData, rdData & 32'h123);
    check(rdData[8] == 1'b0, "R6 write cannot set link-up", rdData[8], 0);
    writeReg(32'h0);
    settle();
  endtask

  task automatic linkCase(input logic [LINK_W-1:0] s, input bit exp);
    @(negedge coreClk); coreLinkState = s;
    repeat (4) @(negedge appClk);
    check(rdData[8] == exp, "R7 link-up flag", rdData[8], exp);
  endtask

  task automatic tLink();
    linkCase(5'h11, 1'b1);
    linkCase(5'h10, 1'b0);
    linkCase(5'h01, 1'b0);
    linkCase(5'h11, 1'b1);
    linkCase(5'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge appClk);
    appRstN = 1'b1; coreRstN = 1'b1;
    tReset();
    tTrain();
    tXlat();
    tAltSet();
    tAltClr();
    tUnused();
    tLink();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule